// File: doc/BRIEF.md
# Selectable Clock Output Generator

This block turns a 32.768 kHz reference clock into a square wave for an open-drain output pin. A 3-bit rate code picks the output frequency. The choices are the reference itself, five binary divisions of it from 16384 Hz down to 1024 Hz, a 1 Hz rate, or no output at all. The divided rates are taken from the taps of one free-running binary prescaler, so each of them has an even 50:50 duty cycle. The full-rate setting passes the reference straight through, and its duty cycle therefore follows the reference.

Two controls override the rate code. A stop request holds the four slowest rates (4096 Hz and below, 1 Hz included) at a steady low, while the three fastest settings keep toggling. During stop the slow prescaler stages are held cleared, so a stopped rate always restarts from its low phase. An active-high output-enable pin, when it is low, puts the pin into high impedance exactly as code 7 does.

The pin is modelled by two signals. The first is a pull-down enable that is asserted whenever the pin must be driven low. The second flags that the output function is switched off. A high level is never driven: it comes from the external pull-up while the pull-down is released. The 1 Hz rate is the one that a later offset-correction stage may disturb. This block keeps that rate clean. All three controls are sampled on the rising reference edge, and they act from that edge on.

Top module: `clkout_gen`

## Requirements
- R1: After reset the output is enabled at the full-rate setting, code 0. `pad_off` is 0 and `pad_pull_low` is the inverse of `clk_ref` (released while the reference is high, pulled low while it is low).
- R2: Codes 1, 2, 3, 4 and 5 give 16384, 8192, 4096, 2048 and 1024 Hz. For code c the high and low phases are each 2^(c-1) reference cycles.
- R3: Code 6 gives 1 Hz. The high and low phases are each 2^(PRESCALE_BITS-1) reference cycles, which is 16384 at the default.
- R4: Code 7 sets `pad_off` to 1 and keeps `pad_pull_low` at 0.
- R5: While `out_en` is 0, the output behaves as under code 7 (`pad_off` = 1, `pad_pull_low` = 0), whatever the rate code.
- R6: While `stop_req` is 1, codes 0, 1 and 2 behave exactly as they do without stop.
- R7: While `stop_req` is 1, codes 3, 4, 5 and 6 hold `pad_pull_low` at 1 and `pad_off` at 0.
- R8: When `stop_req` is released under a stoppable code, the output starts in its low phase. Under code 6 it stays low for at least 16000 cycles after release, and under code 3 it then toggles with 4-cycle phases.
- R9: A change of `rate_sel`, `stop_req` or `out_en` has no effect on the outputs before the next rising `clk_ref` edge, and has taken effect after that edge.
- R10: `pad_pull_low` and `pad_off` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Rate code: 0 is full rate, 1 to 5 are /2 to /32, 6 is 1 Hz, 7 is off |
| stop_req | input | 1 | Stop request: holds the four slowest rates low |
| out_en | input | 1 | Output enable pin, active high; 0 forces high impedance |
| pad_pull_low | output | 1 | Pull-down enable for the open-drain pin |
| pad_off | output | 1 | Output function is in high impedance |

## Verification
The bench measures phase lengths on every divided code, including the 16384-cycle phases of 1 Hz. A tap taken one stage off, or the wrong stage used for 1 Hz, shows up as a halved or doubled phase. It applies stop to every code and checks that the slow rates sit low while the two fast divided rates and the pass-through keep running. A design that gated the wrong set of rates would either freeze a fast rate or let a slow one toggle. After stop is released under the 1 Hz code, the bench checks for a long low stretch; a prescaler that was only masked, not cleared, would resume at a random phase. The bench also probes each control just before and just after the capturing edge, which catches a control that bypasses the register or that lags by an extra cycle.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  localparam int unsigned CODE_W = 3;

  typedef logic [CODE_W-1:0] rate_code_t;

  localparam rate_code_t CODE_FULL    = 3'd0;
  localparam rate_code_t CODE_SLOWEST = 3'd6;
  localparam rate_code_t CODE_OFF     = 3'd7;

  // Captured control state feeding the output stage.
  typedef struct packed {
    rate_code_t code;
    logic       stop;
  } out_ctrl_t;

  // Prescaler stage whose output serves a divided code (1..6).
  function automatic int unsigned tap_of(input int unsigned code,
                                         input int unsigned nbits);
    if (code == 32'(CODE_SLOWEST)) return nbits - 1;
    return code - 1;
  endfunction

endpackage

// File: rtl/clkout_ctrl_capture.sv
module clkout_ctrl_capture
  import clkout_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rate_code_t sel,
  input  logic       stop_req,
  input  logic       oe,
  output out_ctrl_t  ctrl_q
);

  out_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d.code = oe ? sel : CODE_OFF;
    ctrl_d.stop = stop_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.code <= CODE_FULL;
      ctrl_q.stop <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

endmodule

// File: rtl/clkout_prescaler.sv
module clkout_prescaler #(
  parameter int unsigned NBITS     = 15,
  parameter int unsigned RUN_BITS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_slow,
  output logic [NBITS-1:0] taps
);

  localparam logic [NBITS-1:0] SLOW_MASK = {NBITS{1'b1}} << RUN_BITS;

  logic [NBITS-1:0] cnt_q;
  logic [NBITS-1:0] cnt_d;
  logic [NBITS-1:0] carry;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < NBITS; i++) begin : g_stage
    if (i < NBITS - 1) begin : g_carry
      assign carry[i+1] = carry[i] & cnt_q[i];
    end
    if (i < RUN_BITS) begin : g_run
      assign cnt_d[i] = cnt_q[i] ^ carry[i];
    end else begin : g_held
      assign cnt_d[i] = hold_slow ? 1'b0 : (cnt_q[i] ^ carry[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign taps = cnt_q;

  AST_SLOW_STAGES_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    hold_slow |=> ((cnt_q & SLOW_MASK) == '0)); // R7

  AST_FIRST_STAGE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q[0] != $past(cnt_q[0]))); // R6

  AST_RESTART_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_slow) |-> ((cnt_q & SLOW_MASK) == '0)); // R8

endmodule

// File: rtl/clkout_rate_select.sv
module clkout_rate_select
  import clkout_pkg::*;
#(
  parameter int unsigned NBITS    = 15,
  parameter int unsigned RUN_BITS = 2
) (
  input  logic             clk,
  input  out_ctrl_t        ctrl,
  input  logic [NBITS-1:0] taps,
  output logic             pull_low,
  output logic             off
);

  localparam int unsigned NCODES = 1 << CODE_W;

  logic [NCODES-1:0] wave;
  logic              unused_tap_bits;

  assign unused_tap_bits = ^taps;

  assign wave[CODE_FULL] = clk;
  assign wave[CODE_OFF]  = 1'b0;

  for (genvar c = 1; c <= int'(CODE_SLOWEST); c++) begin : g_rate
    localparam int unsigned TAP       = tap_of(c, NBITS);
    localparam bit          STOPPABLE = (TAP >= RUN_BITS);
    if (STOPPABLE) begin : g_gated
      assign wave[c] = taps[TAP] & ~ctrl.stop;
    end else begin : g_free
      assign wave[c] = taps[TAP];
    end
  end

  always_comb begin
    off      = (ctrl.code == CODE_OFF);
    pull_low = !off && !wave[ctrl.code];
  end

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
  import clkout_pkg::*;
#(
  parameter int unsigned PRESCALE_BITS = 15,
  parameter int unsigned RUN_STAGES    = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic       stop_req,
  input  logic       out_en,
  output logic       pad_pull_low,
  output logic       pad_off
);

  out_ctrl_t              ctrl_q;
  logic [PRESCALE_BITS-1:0] taps;

  clkout_ctrl_capture u_capture (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .sel      (rate_sel),
    .stop_req (stop_req),
    .oe       (out_en),
    .ctrl_q   (ctrl_q)
  );

  clkout_prescaler #(
    .NBITS    (PRESCALE_BITS),
    .RUN_BITS (RUN_STAGES)
  ) u_prescaler (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .hold_slow (ctrl_q.stop),
    .taps      (taps)
  );

  clkout_rate_select #(
    .NBITS    (PRESCALE_BITS),
    .RUN_BITS (RUN_STAGES)
  ) u_select (
    .clk      (clk_ref),
    .ctrl     (ctrl_q),
    .taps     (taps),
    .pull_low (pad_pull_low),
    .off      (pad_off)
  );

  AST_CODE7_FLOATS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (rate_sel == 3'd7) |=> (pad_off && !pad_pull_low)); // R4

  AST_PIN_DISABLE_FLOATS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !out_en |=> (pad_off && !pad_pull_low)); // R5

  AST_STOPPED_RATE_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (stop_req && out_en && rate_sel >= 3'd3 && rate_sel <= 3'd6)
      |=> (pad_pull_low && !pad_off)); // R7

  AST_ENABLED_NOT_OFF: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (out_en && rate_sel != 3'd7) |=> !pad_off); // R9

  AST_NO_PULL_WHEN_OFF: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !(pad_off && pad_pull_low)); // R10

endmodule

// File: tb/clkout_gen_test.sv
`timescale 1ns/1ps
module clkout_gen_test;

  logic       clk;
  logic       rst_n;
  logic [2:0] rate_sel;
  logic       stop_req;
  logic       out_en;
  logic       pad_pull_low;
  logic       pad_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int    exp_len_q[$];
  string exp_tag_q[$];
  bit    mon_en = 0;
  int    both_seen = 0;

  clkout_gen uut (
    .clk_ref      (clk),
    .rst_n        (rst_n),
    .rate_sel     (rate_sel),
    .stop_req     (stop_req),
    .out_en       (out_en),
    .pad_pull_low (pad_pull_low),
    .pad_off      (pad_off)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Monitor: measures completed phase lengths and compares with the queue.
  initial begin
    logic cur;
    int   run;
    bit   started;
    started = 0;
    run = 0;
    cur = 1'b0;
    forever begin
      @(negedge clk);
      if (pad_pull_low && pad_off) both_seen++;
      if (!mon_en) begin
        started = 0;
        run = 0;
      end else if (!started && run == 0) begin
        cur = pad_pull_low;
        run = 1;
      end else if (pad_pull_low == cur) begin
        run++;
      end else begin
        if (started && exp_len_q.size() != 0) begin
          int    e;
          string t;
          e = exp_len_q.pop_front();
          t = exp_tag_q.pop_front();
          checks++;
          if (run != e) begin
            fails++;
            $display("FAIL %s: phase length actual %0d expected %0d", t, run, e);
          end
        end
        started = 1;
        cur = pad_pull_low;
        run = 1;
      end
    end
  end

  task automatic apply(input logic [2:0] code, input logic stp, input logic oe);
    @(negedge clk); #1;
    rate_sel = code;
    stop_req = stp;
    out_en   = oe;
  endtask

  // Driver: pushes expected phase lengths, then waits for the monitor.
  task automatic expect_wave(input int half, input int nruns, input string tag);
    repeat (2) @(negedge clk);
    #1;
    for (int k = 0; k < nruns; k++) begin
      exp_len_q.push_back(half);
      exp_tag_q.push_back(tag);
    end
    mon_en = 1;
    while (exp_len_q.size() != 0) @(negedge clk);
    #1;
    mon_en = 0;
  endtask

  task automatic check_hold(input logic exp_pull, input logic exp_off,
                            input int n, input string tag);
    int bad;
    logic ap;
    logic ao;
    bad = 0;
    ap = exp_pull;
    ao = exp_off;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #2;
      if (pad_pull_low !== exp_pull || pad_off !== exp_off) begin
        if (bad == 0) begin
          ap = pad_pull_low;
          ao = pad_off;
        end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: pull_low/off actual %b/%b expected %b/%b",
               tag, ap, ao, exp_pull, exp_off);
    end
  endtask

  task automatic check_pass(input int n, input string tag);
    int bad;
    bad = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      if (pad_pull_low !== 1'b0 || pad_off !== 1'b0) bad++;
      @(negedge clk); #2;
      if (pad_pull_low !== 1'b1 || pad_off !== 1'b0) bad++;
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: pass-through mismatches actual %0d expected 0", tag, bad);
    end
  endtask

  task automatic check_now(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run incomplete actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    rate_sel = 3'd0;
    stop_req = 1'b0;
    out_en   = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state is enabled pass-through
    check_pass(8, "R1");

    // R2: divided rates
    for (int c = 1; c <= 5; c++) begin
      apply(3'(c), 1'b0, 1'b1);
      expect_wave(1 << (c - 1), 6, "R2");
    end

    // R3: 1 Hz
    apply(3'd6, 1'b0, 1'b1);
    expect_wave(16384, 2, "R3");

    // R4: code 7 floats
    apply(3'd7, 1'b0, 1'b1);
    check_hold(1'b0, 1'b1, 40, "R4");

    // R9: rate code change lands at the next rising edge only
    apply(3'd4, 1'b0, 1'b1);
    check_now(pad_off, 1'b1, "R9 before edge");
    @(negedge clk); #2;
    check_now(pad_off, 1'b0, "R9 after edge");
    apply(3'd4, 1'b0, 1'b0);
    check_now(pad_off, 1'b0, "R9 oe before edge");
    @(negedge clk); #2;
    check_now(pad_off, 1'b1, "R9 oe after edge");

    // R5: pin disable overrides any code
    apply(3'd0, 1'b0, 1'b0);
    check_hold(1'b0, 1'b1, 20, "R5 code0");
    apply(3'd2, 1'b0, 1'b0);
    check_hold(1'b0, 1'b1, 20, "R5 code2");
    apply(3'd5, 1'b1, 1'b0);
    check_hold(1'b0, 1'b1, 20, "R5 code5");

    // R6: fast settings ignore stop
    apply(3'd0, 1'b1, 1'b1);
    check_pass(8, "R6 code0");
    apply(3'd1, 1'b1, 1'b1);
    expect_wave(1, 6, "R6 code1");
    apply(3'd2, 1'b1, 1'b1);
    expect_wave(2, 6, "R6 code2");

    // R7: slow settings held low under stop
    for (int c = 3; c <= 6; c++) begin
      apply(3'(c), 1'b1, 1'b1);
      check_hold(1'b1, 1'b0, 50, "R7");
    end

    // R9: stop request lands at the next rising edge only
    apply(3'd5, 1'b0, 1'b1);
    expect_wave(16, 2, "R2 code5 rerun");
    apply(3'd5, 1'b1, 1'b1);
    @(negedge clk); #2;
    check_now(pad_pull_low, 1'b1, "R9 stop after edge");

    // R8: restart from low phase under 1 Hz
    apply(3'd6, 1'b1, 1'b1);
    check_hold(1'b1, 1'b0, 10, "R7 code6");
    apply(3'd6, 1'b0, 1'b1);
    check_hold(1'b1, 1'b0, 16000, "R8 code6");

    // R8: restart under code 3 begins low, then full phases
    apply(3'd3, 1'b1, 1'b1);
    check_hold(1'b1, 1'b0, 10, "R7 code3");
    apply(3'd3, 1'b0, 1'b1);
    @(negedge clk); #2;
    check_now(pad_pull_low, 1'b1, "R8 code3 first phase");
    expect_wave(4, 6, "R8 code3");

    // R10: never pulled low while off
    checks++;
    if (both_seen != 0) begin
      fails++;
      $display("FAIL R10: overlap samples actual %0d expected 0", both_seen);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule